// File: doc/BRIEF.md
# Right Shift and Rotate Execute Unit

This block is the right-shift and right-rotate slice of the execute stage in a 64-bit core. It is purely combinational. The inputs are a 32-bit instruction word from the register-format class, whose primary opcode is zero, and the two source operand values already read from the register file. The outputs are the 64-bit value to write back, the destination register index and a write strobe. A separate flag marks any encoding that the unit does not implement.

The same function code can mean either a logical shift or a rotate. For forms that take the amount from the instruction, the otherwise-idle first source register field picks between the two. For forms that take the amount from a register, the otherwise-idle shift-amount field picks between them. Word forms work on the low half of the operand and sign-extend the 32-bit outcome. One doubleword form adds 32 to the 5-bit immediate amount, so it can reach amounts 32 to 63.

Top module: `rshift_rot_unit`

## Requirements
- R1: The instruction fields are taken from fixed bit positions: opcode [31:26], rs field [25:21], rt field [20:16], rd field [15:11], sa field [10:6], function [5:0]. `dest_idx` always equals bits [15:11].
- R2: Function 0x02 (word, immediate amount sa): rs field 0 gives a logical right shift of `rt_val[31:0]`, and rs field 1 gives a right rotate of it. The 32-bit outcome is sign-extended from its bit 31. Bits [63:32] of `rt_val` have no effect.
- R3: Function 0x3A (doubleword, immediate amount sa): rs field 0 gives a logical right shift of `rt_val`, and rs field 1 gives a 64-bit right rotate.
- R4: Function 0x3E (doubleword, amount sa+32): rs field 0 shifts and rs field 1 rotates `rt_val` right by sa+32, which covers amounts 32 to 63.
- R5: Function 0x06 (word, register amount): sa field 0 gives a logical shift and sa field 1 gives a rotate of `rt_val[31:0]`, with sign extension. The amount is `rs_val[4:0]`, and all higher bits of `rs_val` are ignored.
- R6: Function 0x16 (doubleword, register amount): sa field 0 gives a logical shift and sa field 1 gives a rotate of `rt_val`. The amount is `rs_val[5:0]`, and all higher bits of `rs_val` are ignored.
- R7: A rotate or shift by amount 0 returns the operand unchanged. In the word forms this is the sign-extended low half.
- R8: In the immediate forms (0x02, 0x3A, 0x3E), an rs field of 2 or more is illegal and raises `bad_enc`.
- R9: In the register-amount forms (0x06, 0x16), an sa field of 2 or more is illegal and raises `bad_enc`.
- R10: A nonzero opcode, or any function code other than the five above, raises `bad_enc`.
- R11: When `bad_enc` is 1, `result` is zero and `wr_en` is 0. On every legal encoding, `wr_en` is 1.
- R12: The fixed encodings 0x00252002 (word rotate, rd 4, amount 0), 0x002317FA (doubleword rotate, rd 2, amount 31), 0x0031823E (doubleword rotate by 40, rd 16) and 0x00C52056 (doubleword register rotate, rd 4) decode to those operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word of the register-format class |
| rt_val | input | 64 | Value of the operand that is shifted or rotated |
| rs_val | input | 64 | Value of the register that supplies the variable amount |
| result | output | 64 | Value to write back, zero on an illegal encoding |
| dest_idx | output | 5 | Destination register index, taken from bits [15:11] |
| wr_en | output | 1 | Write-back strobe, low on an illegal encoding |
| bad_enc | output | 1 | High when the encoding is not implemented by this unit |

## Verification
The embedded checks are immediate assertions evaluated inside combinational processes. They assume that `instr`, `rt_val` and `rs_val` carry known values and hold still long enough for the decode, amount and barrel stages to settle before anything reads the outputs. The stimulus changes all three inputs together, once per cycle, on the falling edge. It never drives an unknown value, and it samples the outputs a few nanoseconds after each change. Operands are picked so that shift and rotate give different results, so that the ignored upper bits of `rs_val` and `rt_val` would change the answer if they were used, and so that the sign bit of the word outcome is exercised both set and clear.

// File: rtl/rsr_pkg.sv
// Package: shared constants and types for the right shift/rotate unit.
// Assumes a 32-bit instruction word with the register-format field layout.
package rsr_pkg;

    localparam int INSTR_W = 32;
    localparam int FLD_W   = 5;
    localparam int FN_W    = 6;

    // function codes served by the unit
    localparam logic [FN_W-1:0] FN_WORD_IMM    = 6'h02;
    localparam logic [FN_W-1:0] FN_DBL_IMM     = 6'h3A;
    localparam logic [FN_W-1:0] FN_DBL_IMM_HI  = 6'h3E;
    localparam logic [FN_W-1:0] FN_WORD_REG    = 6'h06;
    localparam logic [FN_W-1:0] FN_DBL_REG     = 6'h16;

    // where the shift amount comes from
    typedef enum logic [1:0] {
        SRC_FIELD    = 2'd0,   // immediate sa field
        SRC_FIELD_HI = 2'd1,   // immediate sa field plus 32
        SRC_REG      = 2'd2    // low bits of the rs operand value
    } amt_src_e;

    // instruction fields, most significant first
    typedef struct packed {
        logic [FN_W-1:0]  opc;
        logic [FLD_W-1:0] rs;
        logic [FLD_W-1:0] rt;
        logic [FLD_W-1:0] rd;
        logic [FLD_W-1:0] sa;
        logic [FN_W-1:0]  fn;
    } fields_t;

    // decoded control word
    typedef struct packed {
        logic             legal;
        logic             word;
        logic             rotate;
        amt_src_e         src;
        logic [FLD_W-1:0] rd;
    } ctrl_t;

endpackage

// File: rtl/rsr_decode.sv
// Module: rsr_decode
// Splits the instruction word into fields and classifies it as one of the
// five shift/rotate forms. Anything else is marked not legal.
// Assumes: instr is a stable, known value when sampled downstream.
module rsr_decode
    import rsr_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl
);

    fields_t f;
    logic    unused_rt;

    // field split by fixed bit position
    assign f         = fields_t'(instr);
    assign unused_rt = ^f.rt;

    // classify function code and selector field
    always_comb begin
        ctrl        = '0;
        ctrl.src    = SRC_FIELD;
        ctrl.rd     = f.rd;
        if (f.opc == '0) begin
            case (f.fn)
                FN_WORD_IMM: begin
                    ctrl.legal  = (f.rs <= 5'd1);
                    ctrl.word   = 1'b1;
                    ctrl.rotate = f.rs[0];
                    ctrl.src    = SRC_FIELD;
                end
                FN_DBL_IMM: begin
                    ctrl.legal  = (f.rs <= 5'd1);
                    ctrl.word   = 1'b0;
                    ctrl.rotate = f.rs[0];
                    ctrl.src    = SRC_FIELD;
                end
                FN_DBL_IMM_HI: begin
                    ctrl.legal  = (f.rs <= 5'd1);
                    ctrl.word   = 1'b0;
                    ctrl.rotate = f.rs[0];
                    ctrl.src    = SRC_FIELD_HI;
                end
                FN_WORD_REG: begin
                    ctrl.legal  = (f.sa <= 5'd1);
                    ctrl.word   = 1'b1;
                    ctrl.rotate = f.sa[0];
                    ctrl.src    = SRC_REG;
                end
                FN_DBL_REG: begin
                    ctrl.legal  = (f.sa <= 5'd1);
                    ctrl.word   = 1'b0;
                    ctrl.rotate = f.sa[0];
                    ctrl.src    = SRC_REG;
                end
                default: begin
                    ctrl.legal  = 1'b0;
                end
            endcase
        end
    end

    // guard the classification against the raw fields
    always_comb begin
        if (f.opc != '0) begin
            assert_opc_reject_R10: assert (!ctrl.legal)
                else $error("nonzero opcode accepted");
        end
        if (ctrl.legal && ctrl.src != SRC_REG) begin
            assert_imm_selector_R8: assert (f.rs <= 5'd1)
                else $error("immediate form accepted with rs field %0d", f.rs);
        end
        if (ctrl.legal && ctrl.src == SRC_REG) begin
            assert_reg_selector_R9: assert (f.sa <= 5'd1)
                else $error("register form accepted with sa field %0d", f.sa);
        end
    end

endmodule

// File: rtl/rsr_amount.sv
// Module: rsr_amount
// Forms the effective shift amount from the sa field, from the sa field
// plus 32, or from the low bits of the rs operand value.
// Assumes: XLEN is a power of two, and the word size is XLEN/2.
module rsr_amount
    import rsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  amt_src_e           src,
    input  logic               word,
    input  logic [FLD_W-1:0]   sa_fld,
    input  logic [$clog2(XLEN)-1:0] rs_low,
    output logic [$clog2(XLEN)-1:0] amt
);

    localparam int AW  = $clog2(XLEN);
    localparam int HAW = AW - 1;

    // choose amount source; word register forms drop the top bit
    always_comb begin
        case (src)
            SRC_FIELD:    amt = AW'(sa_fld);
            SRC_FIELD_HI: amt = {1'b1, sa_fld[HAW-1:0]};
            SRC_REG:      amt = word ? {1'b0, rs_low[HAW-1:0]} : rs_low;
            default:      amt = '0;
        endcase
    end

    // plus-32 form lands in upper range; word amounts stay below 32
    always_comb begin
        if (src == SRC_FIELD_HI) begin
            assert_hi_range_R4: assert (amt >= AW'(XLEN/2))
                else $error("plus-32 amount %0d below half width", amt);
        end
        if (word && src == SRC_REG) begin
            assert_word_amt_R5: assert (amt < AW'(XLEN/2))
                else $error("word amount %0d out of range", amt);
        end
    end

endmodule

// File: rtl/rsr_barrel.sv
// Module: rsr_barrel
// Logarithmic right barrel: one stage per amount bit. In rotate mode the
// bits leaving the bottom re-enter at the top; otherwise zeros fill.
// Assumes: W is a power of two.
module rsr_barrel #(
    parameter int W = 64
) (
    input  logic [W-1:0]         data_in,
    input  logic [$clog2(W)-1:0] amt,
    input  logic                 rotate,
    output logic [W-1:0]         data_out
);

    localparam int SW = $clog2(W);

    logic [SW:0][W-1:0] stage;

    assign stage[0] = data_in;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        logic [W-1:0] moved;

        // shift this stage by its power of two, wrapping when rotating
        always_comb begin
            moved = stage[i] >> STEP;
            if (rotate) begin
                moved[W-1 -: STEP] = stage[i][STEP-1:0];
            end
        end

        assign stage[i+1] = amt[i] ? moved : stage[i];
    end

    assign data_out = stage[SW];

    // amount zero passes through; rotation keeps ones; shift clears MSB
    always_comb begin
        if (amt == '0) begin
            assert_zero_amt_R7: assert (data_out == data_in)
                else $error("zero amount altered data");
        end
        if (rotate) begin
            assert_rot_keeps_ones_R3: assert ($countones(data_out) == $countones(data_in))
                else $error("rotate changed population count");
        end
        if (!rotate && amt != '0) begin
            assert_shift_fills_zero_R2: assert (data_out[W-1] == 1'b0)
                else $error("logical shift left MSB set");
        end
    end

endmodule

// File: rtl/rshift_rot_unit.sv
// Module: rshift_rot_unit
// Combinational right shift/rotate execute unit. Word forms run on the low
// half of rt_val and sign-extend; doubleword forms run on all of rt_val.
// An unsupported encoding yields zero, a low write strobe and bad_enc.
// Assumes: the core has already read rt_val and rs_val; no storage here.
module rshift_rot_unit
    import rsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [XLEN-1:0]    rt_val,
    input  logic [XLEN-1:0]    rs_val,
    output logic [XLEN-1:0]    result,
    output logic [FLD_W-1:0]   dest_idx,
    output logic               wr_en,
    output logic               bad_enc
);

    localparam int HALF = XLEN / 2;
    localparam int AW   = $clog2(XLEN);
    localparam int HAW  = $clog2(HALF);

    ctrl_t            ctrl;
    fields_t          f;
    logic [AW-1:0]    amt;
    logic [HALF-1:0]  word_out;
    logic [XLEN-1:0]  dbl_out;
    logic [XLEN-1:0]  result_c;
    logic             unused_rs_hi;

    assign f            = fields_t'(instr);
    assign unused_rs_hi = ^rs_val[XLEN-1:AW];

    rsr_decode u_decode (
        .instr (instr),
        .ctrl  (ctrl)
    );

    rsr_amount #(.XLEN(XLEN)) u_amount (
        .src    (ctrl.src),
        .word   (ctrl.word),
        .sa_fld (f.sa),
        .rs_low (rs_val[AW-1:0]),
        .amt    (amt)
    );

    rsr_barrel #(.W(HALF)) u_word_barrel (
        .data_in  (rt_val[HALF-1:0]),
        .amt      (amt[HAW-1:0]),
        .rotate   (ctrl.rotate),
        .data_out (word_out)
    );

    rsr_barrel #(.W(XLEN)) u_dbl_barrel (
        .data_in  (rt_val),
        .amt      (amt),
        .rotate   (ctrl.rotate),
        .data_out (dbl_out)
    );

    // pick width, sign-extend word outcome, force zero when illegal
    always_comb begin
        result_c = '0;
        if (ctrl.legal) begin
            result_c = ctrl.word ? {{HALF{word_out[HALF-1]}}, word_out} : dbl_out;
        end
    end

    assign result   = result_c;
    assign dest_idx = ctrl.rd;
    assign bad_enc  = ~ctrl.legal;
    assign wr_en    = ctrl.legal;

    // output consistency checks
    always_comb begin
        if (bad_enc) begin
            assert_bad_is_quiet_R11: assert (result == '0 && !wr_en)
                else $error("illegal encoding produced output");
        end
        if (!bad_enc && ctrl.word) begin
            assert_word_sext_R5: assert (result[XLEN-1:HALF] == {HALF{result[HALF-1]}})
                else $error("word result not sign-extended");
        end
    end

endmodule

// File: tb/rshift_rot_unit_bench.sv
module rshift_rot_unit_bench;

    localparam time PERIOD = 8ns;
    localparam logic [63:0] OPA = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] OPB = 64'hFFFF_FFFF_0000_0001;

    typedef struct packed {
        logic [31:0] ins;
        logic [63:0] rt;
        logic [63:0] rs;
        logic [63:0] exp;
        logic        bad;
    } vec_t;

    function automatic logic [31:0] enc(input logic [4:0] rs_f, input logic [4:0] rt_f,
                                        input logic [4:0] rd_f, input logic [4:0] sa_f,
                                        input logic [5:0] fn);
        return {6'd0, rs_f, rt_f, rd_f, sa_f, fn};
    endfunction

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{enc(0,5,4,4,6'h02),  OPA, 64'd0,    64'h0000_0000_089A_BCDE, 1'b0}, // R2 shift
        '{enc(1,5,4,4,6'h02),  OPA, 64'd0,    64'hFFFF_FFFF_F89A_BCDE, 1'b0}, // R2 rotate
        '{enc(1,5,4,0,6'h02),  OPA, 64'd0,    64'hFFFF_FFFF_89AB_CDEF, 1'b0}, // R7 word rotate 0
        '{enc(0,5,4,0,6'h02),  OPA, 64'd0,    64'hFFFF_FFFF_89AB_CDEF, 1'b0}, // R7 word shift 0
        '{enc(1,5,7,1,6'h02),  OPB, 64'd0,    64'hFFFF_FFFF_8000_0000, 1'b0}, // R2 upper ignored
        '{enc(0,5,7,1,6'h02),  OPB, 64'd0,    64'h0,                   1'b0}, // R2 upper ignored
        '{enc(0,3,2,8,6'h3A),  OPA, 64'd0,    64'h0001_2345_6789_ABCD, 1'b0}, // R3 shift
        '{enc(1,3,2,8,6'h3A),  OPA, 64'd0,    64'hEF01_2345_6789_ABCD, 1'b0}, // R3 rotate
        '{enc(1,3,2,0,6'h3A),  OPA, 64'd0,    OPA,                     1'b0}, // R7 dword rotate 0
        '{enc(0,3,9,0,6'h3E),  OPA, 64'd0,    64'h0000_0000_0123_4567, 1'b0}, // R4 shift 32
        '{enc(1,3,9,0,6'h3E),  OPA, 64'd0,    64'h89AB_CDEF_0123_4567, 1'b0}, // R4 rotate 32
        '{enc(1,3,9,31,6'h3E), OPA, 64'd0,    64'h0246_8ACF_1357_9BDE, 1'b0}, // R4 rotate 63
        '{enc(0,3,9,31,6'h3E), OPA, 64'd0,    64'h0,                   1'b0}, // R4 shift 63
        '{enc(6,5,4,0,6'h06),  OPA, 64'h24,   64'h0000_0000_089A_BCDE, 1'b0}, // R5 low 5 bits
        '{enc(6,5,4,1,6'h06),  OPA, 64'h4,    64'hFFFF_FFFF_F89A_BCDE, 1'b0}, // R5 rotate
        '{enc(6,5,4,1,6'h16),  OPA, 64'h48,   64'hEF01_2345_6789_ABCD, 1'b0}, // R6 low 6 bits
        '{enc(6,5,4,0,6'h16),  OPA, 64'h44,   64'h0012_3456_789A_BCDE, 1'b0}, // R6 shift
        '{enc(2,3,2,8,6'h3A),  OPA, 64'd0,    64'h0,                   1'b1}, // R8
        '{enc(31,5,4,4,6'h02), OPA, 64'd0,    64'h0,                   1'b1}, // R8
        '{enc(6,5,4,2,6'h06),  OPA, 64'h4,    64'h0,                   1'b1}, // R9
        '{enc(6,5,4,31,6'h16), OPA, 64'h4,    64'h0,                   1'b1}, // R9
        '{enc(0,5,4,4,6'h03),  OPA, 64'd0,    64'h0,                   1'b1}, // R10 other function
        '{32'h0425_2002,       OPA, 64'd0,    64'h0,                   1'b1}, // R10 nonzero opcode
        '{32'h0025_2002,       OPA, 64'd0,    64'hFFFF_FFFF_89AB_CDEF, 1'b0}, // R12
        '{32'h0023_17FA,       OPA, 64'd0,    64'h1357_9BDE_0246_8ACF, 1'b0}, // R12
        '{32'h0031_823E,       OPA, 64'd0,    64'h6789_ABCD_EF01_2345, 1'b0}, // R12
        '{32'h00C5_2056,       OPA, 64'h8,    64'hEF01_2345_6789_ABCD, 1'b0}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rt_val = '0;
    logic [63:0] rs_val = '0;
    logic [63:0] result;
    logic [4:0]  dest_idx;
    logic        wr_en;
    logic        bad_enc;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rshift_rot_unit u_rshift_rot_unit (
        .instr    (instr),
        .rt_val   (rt_val),
        .rs_val   (rs_val),
        .result   (result),
        .dest_idx (dest_idx),
        .wr_en    (wr_en),
        .bad_enc  (bad_enc)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [63:0] t, input logic [63:0] s);
        @(negedge clk);
        instr  = i;
        rt_val = t;
        rs_val = s;
        #2ns;
    endtask

    function automatic logic [63:0] ror64(input logic [63:0] x, input int n);
        return (n == 0) ? x : ((x >> n) | (x << (64 - n)));
    endfunction

    function automatic logic [63:0] ror32x(input logic [31:0] x, input int n);
        logic [31:0] r;
        r = (n == 0) ? x : ((x >> n) | (x << (32 - n)));
        return {{32{r[31]}}, r};
    endfunction

    initial begin
        // reset state: all inputs zero, an unsupported function code
        repeat (2) @(negedge clk);
        #2ns;
        check("R11 reset result",  result, 64'h0);
        check("R11 reset bad_enc", 64'(bad_enc), 64'h1);
        check("R11 reset wr_en",   64'(wr_en), 64'h0);
        rst_n = 1'b1;

        // table walk
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].ins, VECS[k].rt, VECS[k].rs);
            check($sformatf("R2-table vec %0d result", k), result, VECS[k].exp);
            check($sformatf("R11 vec %0d bad_enc", k), 64'(bad_enc), 64'(VECS[k].bad));
            check($sformatf("R11 vec %0d wr_en", k), 64'(wr_en), 64'(!VECS[k].bad));
            check($sformatf("R1 vec %0d dest_idx", k), 64'(dest_idx), 64'(VECS[k].ins[15:11]));
        end

        // R6 sweep: register-amount doubleword rotate across all amounts
        for (int n = 0; n < 64; n++) begin
            apply(enc(6,5,19,1,6'h16), 64'hF0E1_D2C3_B4A5_9687, 64'hFF00 | 64'(n));
            check($sformatf("R6 drotv amt %0d", n), result, ror64(64'hF0E1_D2C3_B4A5_9687, n));
        end

        // R5 sweep: register-amount word rotate, upper bits of rs ignored
        for (int n = 0; n < 32; n++) begin
            apply(enc(6,5,3,1,6'h06), 64'h1111_2222_8001_00F3, 64'hE0 | 64'(n));
            check($sformatf("R5 rotv amt %0d", n), result, ror32x(32'h8001_00F3, n));
        end

        // R4 sweep: plus-32 rotate equals rotate by sa+32
        for (int n = 0; n < 32; n++) begin
            apply(enc(1,5,30,5'(n),6'h3E), 64'hA5A5_0F0F_3C3C_9999, 64'd0);
            check($sformatf("R4 plus32 sa %0d", n), result, ror64(64'hA5A5_0F0F_3C3C_9999, n + 32));
            check($sformatf("R1 plus32 dest %0d", n), 64'(dest_idx), 64'd30);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule